// File: doc/BRIEF.md
# TDC Hit Timestamp Assembler

This block turns one captured hit of a two-stage time-to-digital converter into an absolute timestamp. The first stage is a 32-tap delay line locked to one reference clock period. Each tap is split into 4 interpolated sub-bins, which gives 128 fine bins per period. The captured state of those 128 bins is a circular run of ones. Its single falling transition marks where the hit landed inside the reference cycle, and the block encodes that transition as a 7-bit fine code.

A hit is asynchronous to the coarse counter. The counter is therefore captured as two copies. One copy advances at the start of each reference cycle and the other advances at mid-cycle. The fine code shows which copy could not have been changing when the hit was captured, and the block takes the coarse value from that copy. It corrects the value when that copy already points at the next cycle.

The joined value, coarse count times 128 plus fine code, is held in a one-deep output register with a valid/ready handshake. A capture with no clean transition raises an error pulse. A good hit that finds the output stalled is dropped and raises an overflow pulse.

Top module: `tdc_ts_assembler`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, tsValid, errFlag and ovfFlag are low.
- R2: The fine code is the index k for which tapVec[k] is 1 and tapVec[(k+1) mod 128] is 0. Index 0 is the earliest sub-bin, and the capture is valid only when exactly one such k exists.
- R3: A hit whose capture has zero or several such transitions causes errFlag to be high on the cycle after the hit. tsValid does not become high for it and tsData is left unchanged.
- R4: When the fine code lies in 32..95, the coarse value is cntRise, the copy that advances at cycle start.
- R5: When the fine code lies in 0..31, the coarse value is cntMid, the copy that advances at mid-cycle.
- R6: When the fine code lies in 96..127, the coarse value is cntMid minus 1, wrapping modulo 2^16.
- R7: tsData equals coarse*128 + fine code: coarse in bits 22:7 and the fine code in bits 6:0.
- R8: A good hit accepted while the output is free shows tsValid high on the next cycle. tsValid and tsData then hold steady for as long as tsReady stays low.
- R9: A good hit that arrives while tsValid is high and tsReady is low is dropped. ovfFlag is high on the next cycle, and tsValid and tsData keep the earlier item.
- R10: A good hit that arrives in the same cycle that tsReady takes the held item is accepted. The new item appears on the next cycle with no overflow.
- R11: errFlag and ovfFlag are single-cycle pulses, low on any cycle not caused by a hit as in R3 or R9, and never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-derived system clock |
| rstN | input | 1 | Active-low synchronous reset |
| hitValid | input | 1 | Captured vectors below hold a hit this cycle |
| tapVec | input | 128 | Captured state of the 32x4 fine bins, bit 0 earliest |
| cntRise | input | 16 | Counter copy that advances at cycle start |
| cntMid | input | 16 | Counter copy that advances at mid-cycle |
| tsReady | input | 1 | Consumer accepts the held timestamp |
| tsValid | output | 1 | Held timestamp is valid |
| tsData | output | 23 | Coarse count and fine code |
| errFlag | output | 1 | Pulse: capture had no single clean transition |
| ovfFlag | output | 1 | Pulse: good hit dropped because the output was stalled |

## Verification
The assertions take for granted that the two counter copies satisfy the stated phase relation: cntMid equals cntRise during the first half of a cycle and cntRise+1 during the second half. The correction in R6 is correct only under that relation. The stimulus table picks counter pairs per quadrant by hand, so the expected coarse value follows from the quadrant rule alone. It also covers captures that wrap around bit 127 to bit 0. The handshake properties assume tsReady and hitValid are stable across each clock edge, and the bench drives both only on falling edges.

// File: rtl/tdc_ts_pkg.sv
package tdc_ts_pkg;

  // Strobes issued by control to the datapath for the current hit.
  typedef struct packed {
    logic load;   // accept the hit into the output register
    logic drop;   // good hit lost to a stalled output
    logic bad;    // capture without a single clean transition
  } tsStrobe_t;

endpackage

// File: rtl/tdc_fine_encoder.sv
module tdc_fine_encoder #(
  parameter int N = 128,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] tapVec,
  output logic [W-1:0] fineCode,
  output logic         codeOk
);

  logic [N-1:0] edgeVec;

  // One marker per circular 1->0 step along the line.
  for (genvar i = 0; i < N; i++) begin : g_edge
    assign edgeVec[i] = tapVec[i] & ~tapVec[(i + 1) % N];
  end

  // Exactly one marker: non-empty and a power of two.
  assign codeOk = (edgeVec != '0) && ((edgeVec & (edgeVec - 1'b1)) == '0);

  // OR-encode the marker position; exact when codeOk holds.
  always_comb begin
    fineCode = '0;
    for (int i = 0; i < N; i++) begin
      if (edgeVec[i]) fineCode = fineCode | W'(i);
    end
  end

endmodule

// File: rtl/tdc_ts_datapath.sv
module tdc_ts_datapath
  import tdc_ts_pkg::*;
#(
  parameter int TAPS  = 32,
  parameter int SUBS  = 4,
  parameter int CNT_W = 16,
  localparam int FINE_N = TAPS * SUBS,
  localparam int FINE_W = $clog2(FINE_N),
  localparam int TS_W   = CNT_W + FINE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FINE_N-1:0] tapVec,
  input  logic [CNT_W-1:0]  cntRise,
  input  logic [CNT_W-1:0]  cntMid,
  input  tsStrobe_t         strobe,
  output logic              codeOk,
  output logic [TS_W-1:0]   tsData,
  output logic              errFlag,
  output logic              ovfFlag
);

  logic [FINE_W-1:0] fineCode;
  logic [1:0]        quadrant;
  logic [CNT_W-1:0]  coarse;

  tdc_fine_encoder #(.N(FINE_N)) u_enc (
    .tapVec  (tapVec),
    .fineCode(fineCode),
    .codeOk  (codeOk)
  );

  // Take the counter copy whose own transition is a quarter period away.
  assign quadrant = fineCode[FINE_W-1 -: 2];

  always_comb begin
    unique case (quadrant)
      2'd0:    coarse = cntMid;
      2'd3:    coarse = CNT_W'(cntMid - 1'b1);
      default: coarse = cntRise;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsData  <= '0;
      errFlag <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      if (strobe.load) tsData <= {coarse, fineCode};
      errFlag <= strobe.bad;
      ovfFlag <= strobe.drop;
    end
  end

  // R2
  fine_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeOk |-> (tapVec[fineCode] && !tapVec[FINE_W'(fineCode + 1'b1)]));

endmodule

// File: rtl/tdc_ts_control.sv
module tdc_ts_control
  import tdc_ts_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hitValid,
  input  logic      codeOk,
  input  logic      tsReady,
  output tsStrobe_t strobe,
  output logic      tsValid
);

  logic busy;

  assign busy        = tsValid && !tsReady;
  assign strobe.bad  = hitValid && !codeOk;
  assign strobe.load = hitValid && codeOk && !busy;
  assign strobe.drop = hitValid && codeOk && busy;

  always_ff @(posedge clk) begin
    if (!rstN)            tsValid <= 1'b0;
    else if (strobe.load) tsValid <= 1'b1;
    else if (tsReady)     tsValid <= 1'b0;
  end

  // R8
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tsValid && !tsReady) |=> tsValid);

  // R10
  b2b_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitValid && codeOk && tsValid && tsReady) |=> tsValid);

endmodule

// File: rtl/tdc_ts_assembler.sv
module tdc_ts_assembler
  import tdc_ts_pkg::*;
#(
  parameter int TAPS  = 32,
  parameter int SUBS  = 4,
  parameter int CNT_W = 16,
  localparam int FINE_N = TAPS * SUBS,
  localparam int TS_W   = CNT_W + $clog2(FINE_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hitValid,
  input  logic [FINE_N-1:0] tapVec,
  input  logic [CNT_W-1:0]  cntRise,
  input  logic [CNT_W-1:0]  cntMid,
  input  logic              tsReady,
  output logic              tsValid,
  output logic [TS_W-1:0]   tsData,
  output logic              errFlag,
  output logic              ovfFlag
);

  tsStrobe_t strobe;
  logic      codeOk;

  tdc_ts_control u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hitValid(hitValid),
    .codeOk  (codeOk),
    .tsReady (tsReady),
    .strobe  (strobe),
    .tsValid (tsValid)
  );

  tdc_ts_datapath #(.TAPS(TAPS), .SUBS(SUBS), .CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .tapVec (tapVec),
    .cntRise(cntRise),
    .cntMid (cntMid),
    .strobe (strobe),
    .codeOk (codeOk),
    .tsData (tsData),
    .errFlag(errFlag),
    .ovfFlag(ovfFlag)
  );

  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tsValid && !tsReady) |=> $stable(tsData));

  // R3
  bad_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitValid && !codeOk) |=> (errFlag && $stable(tsData)));

  // R9
  drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitValid && codeOk && tsValid && !tsReady) |=> (ovfFlag && tsValid && $stable(tsData)));

  // R11
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !ovfFlag);

endmodule

// File: tb/tb_tdc_ts_assembler.sv
module tb_tdc_ts_assembler;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         hitValid = 1'b0;
  logic [127:0] tapVec = '0;
  logic [15:0]  cntRise = '0;
  logic [15:0]  cntMid = '0;
  logic         tsReady = 1'b0;
  logic         tsValid;
  logic [22:0]  tsData;
  logic         errFlag;
  logic         ovfFlag;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tdc_ts_assembler dut (
    .clk(clk), .rstN(rstN), .hitValid(hitValid), .tapVec(tapVec),
    .cntRise(cntRise), .cntMid(cntMid), .tsReady(tsReady),
    .tsValid(tsValid), .tsData(tsData), .errFlag(errFlag), .ovfFlag(ovfFlag)
  );

  typedef struct packed {
    logic [6:0]  idx;
    logic [7:0]  run;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] coarse;
  } vec_t;

  // Edge index, run length of ones, cntRise, cntMid, expected coarse.
  localparam vec_t TBL [8] = '{
    '{7'd40,  8'd10,  16'h1234, 16'h9999, 16'h1234},  // R4
    '{7'd95,  8'd60,  16'h0005, 16'h0006, 16'h0005},  // R4 upper edge
    '{7'd32,  8'd1,   16'h0100, 16'h0000, 16'h0100},  // R4 lower edge
    '{7'd31,  8'd20,  16'hAAAA, 16'h0777, 16'h0777},  // R5
    '{7'd0,   8'd5,   16'h1111, 16'h2222, 16'h2222},  // R5 wrapped run
    '{7'd96,  8'd30,  16'h0000, 16'h0050, 16'h004F},  // R6
    '{7'd127, 8'd127, 16'h0000, 16'h0000, 16'hFFFF},  // R6 wrap
    '{7'd64,  8'd64,  16'hFFFF, 16'h0001, 16'hFFFF}   // R4
  };

  function automatic logic [127:0] mkVec(int idx, int run);
    logic [127:0] v = '0;
    for (int j = 0; j < run; j++) v[(idx - j + 128) % 128] = 1'b1;
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // Drive on a falling edge, sample just after the next rising edge.
  task automatic step(logic [127:0] v, logic [15:0] a, logic [15:0] b,
                      logic hv, logic rdy);
    @(negedge clk);
    tapVec = v; cntRise = a; cntMid = b; hitValid = hv; tsReady = rdy;
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic [22:0] held;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid in reset", 32'(tsValid), 0);
    chk("R1 err in reset", 32'(errFlag), 0);
    chk("R1 ovf in reset", 32'(ovfFlag), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 valid after reset", 32'(tsValid), 0);
    chk("R1 flags after reset", 32'({errFlag, ovfFlag}), 0);

    for (int i = 0; i < 8; i++) begin
      step(mkVec(TBL[i].idx, TBL[i].run), TBL[i].a, TBL[i].b, 1'b1, 1'b1);
      chk($sformatf("R8 valid entry %0d", i), 32'(tsValid), 1);
      chk($sformatf("R2/R7 data entry %0d", i), 32'(tsData),
          32'({TBL[i].coarse, TBL[i].idx}));
      step('0, '0, '0, 1'b0, 1'b1);
      chk($sformatf("R11 flags idle entry %0d", i), 32'({errFlag, ovfFlag}), 0);
      chk($sformatf("R8 pop entry %0d", i), 32'(tsValid), 0);
    end

    // R3: bubble, empty and full captures are rejected.
    held = tsData;
    step(mkVec(20, 5) | mkVec(80, 5), 16'h0033, 16'h0033, 1'b1, 1'b1);
    chk("R3 bubble err", 32'(errFlag), 1);
    chk("R3 bubble no valid", 32'(tsValid), 0);
    chk("R3 bubble data kept", 32'(tsData), 32'(held));
    chk("R11 no ovf on bubble", 32'(ovfFlag), 0);
    step('0, '0, '0, 1'b1, 1'b1);
    chk("R3 empty err", 32'(errFlag), 1);
    step('1, '0, '0, 1'b1, 1'b1);
    chk("R3 full err", 32'(errFlag), 1);
    chk("R3 full no valid", 32'(tsValid), 0);
    step('0, '0, '0, 1'b0, 1'b1);
    chk("R11 err pulse ends", 32'(errFlag), 0);

    // R8/R9: stall, hold and drop.
    step(mkVec(50, 9), 16'h0042, 16'h0043, 1'b1, 1'b0);
    chk("R8 accept A", 32'(tsValid), 1);
    chk("R7 data A", 32'(tsData), 32'({16'h0042, 7'd50}));
    step('0, '0, '0, 1'b0, 1'b0);
    step('0, '0, '0, 1'b0, 1'b0);
    chk("R8 stall valid", 32'(tsValid), 1);
    chk("R8 stall data", 32'(tsData), 32'({16'h0042, 7'd50}));
    step(mkVec(70, 3), 16'h0100, 16'h0101, 1'b1, 1'b0);
    chk("R9 ovf pulse", 32'(ovfFlag), 1);
    chk("R9 valid kept", 32'(tsValid), 1);
    chk("R9 data kept", 32'(tsData), 32'({16'h0042, 7'd50}));
    step('0, '0, '0, 1'b0, 1'b0);
    chk("R11 ovf pulse ends", 32'(ovfFlag), 0);

    // R10: new hit while the held item is taken.
    step(mkVec(10, 4), 16'h0200, 16'h0201, 1'b1, 1'b1);
    chk("R10 b2b valid", 32'(tsValid), 1);
    chk("R10 b2b data", 32'(tsData), 32'({16'h0201, 7'd10}));
    chk("R10 b2b no ovf", 32'(ovfFlag), 0);
    step('0, '0, '0, 1'b0, 1'b1);
    chk("R8 final pop", 32'(tsValid), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule